// File: doc/BRIEF.md
# Two-Stage Interrupt Pending Controller

This block gathers up to 32 interrupt sources and presents them to a processor on two request lines: a normal line and a fast line. Each source records a request in a source-pending register. How it records depends on the source's trigger kind, which is fixed by a parameter:

- A level source records on every cycle its input is high.
- An edge source records only on a rising edge of its input.

A few bit positions are reserved and never record anything.

The pending requests that are unmasked and not routed to the fast line compete by position. The lowest-numbered one is copied, one-hot, into a single in-service register, but only while that register is empty. The normal request line stays high for as long as the in-service register holds a bit.

A mode register can steer at most one source to the fast line instead. That line is high while the steered source is pending and unmasked. Software clears a serviced request by writing ones, first to the pending register and then to the in-service register. A read-only index register reports the position of the bit in service.

The register port is a plain single-cycle write strobe with a combinational read. It has no handshake and never applies back-pressure. A write takes effect at the clock edge where the strobe is high. A read returns the register addressed on the same cycle.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset the pending, in-service and mode registers read zero, the mask register reads all ones, and both request outputs are low.
- R2: Trigger kinds follow the LEVEL_MASK parameter, a 1 meaning level; the default level positions are 4, 5, 15, 23, 28 and 31. A level source sets its pending bit on every cycle its input is high, so clearing that bit while the input stays high leaves it set. An edge source sets the bit once per rising edge, so clearing it while the input stays high leaves it clear.
- R3: A mask bit of 1 keeps its source out of the in-service register and off the fast line, while the pending bit still records. A mask bit of 0 enables the source. The mask register is at offset 0x08.
- R4: When the in-service register is empty, it is loaded with the one-hot bit of the lowest-numbered source that is pending, unmasked and not routed to the fast line. While it is non-empty it keeps its value until software clears it, even if a lower-numbered source becomes pending.
- R5: Writing ones to the pending register (offset 0x00) or to the in-service register (offset 0x10) clears those bits, and bits written as zero are unchanged. A source that sets a pending bit on the same cycle it is cleared leaves the bit set.
- R6: The mode register (offset 0x04) accepts a write with at most one bit set and ignores a write with two or more bits set. The routed source never enters the in-service register. The fast output is high while that source's pending bit is set and its mask bit is 0.
- R7: The normal output is high exactly while the in-service register is non-zero. The index register (offset 0x14) reads the binary position of the in-service bit, or zero when none is in service.
- R8: Positions in the RSVD_MASK parameter never set their pending bit. The default reserved positions are 6 and 24.
- R9: With up to three edge requests left pending and unmasked, repeating the pass "read the in-service register, write that value to the pending register, then write it to the in-service register" leaves both registers zero within four passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req_i | input | NSRC (32) | Per-source request inputs |
| bus_wr_i | input | 1 | Register write strobe, one write per cycle it is high |
| bus_addr_i | input | 5 | Byte offset of the register accessed |
| bus_wdata_i | input | NSRC (32) | Write data |
| bus_rdata_o | output | NSRC (32) | Read data of the register at bus_addr_i |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
On every cycle the assertions check the following:

- The in-service and mode registers never hold more than one bit.
- The in-service register keeps its value until it is written.
- A newly loaded in-service bit was neither masked nor routed to the fast line on the cycle it was chosen.
- A write of ones to the pending register clears every bit that no source re-set.
- The index always points at the bit in service.

Several behaviours can only be shown by the bench's scenarios:

- which source wins the priority contest;
- the difference between edge and level sources whose input stays high;
- a mode write with several bits set being ignored;
- the fast line following mask changes;
- the four-pass cleanup sequence after stale requests.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

  localparam int unsigned OFS_W = 5;

  localparam logic [OFS_W-1:0] OFS_PEND  = 5'h00;
  localparam logic [OFS_W-1:0] OFS_MODE  = 5'h04;
  localparam logic [OFS_W-1:0] OFS_MASK  = 5'h08;
  localparam logic [OFS_W-1:0] OFS_INSVC = 5'h10;
  localparam logic [OFS_W-1:0] OFS_INDEX = 5'h14;

  typedef enum logic [2:0] {
    SEL_PEND,
    SEL_MODE,
    SEL_MASK,
    SEL_INSVC,
    SEL_INDEX,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
    case (ofs)
      OFS_PEND:  return SEL_PEND;
      OFS_MODE:  return SEL_MODE;
      OFS_MASK:  return SEL_MASK;
      OFS_INSVC: return SEL_INSVC;
      OFS_INDEX: return SEL_INDEX;
      default:   return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irq_src_capture.sv
// Turns raw request inputs into per-cycle set pulses, by trigger kind.
module irq_src_capture #(
  parameter int unsigned     NSRC       = 32,
  parameter logic [NSRC-1:0] LEVEL_MASK = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  output logic [NSRC-1:0] set_o
);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (LEVEL_MASK[i]) begin : g_level
      assign set_o[i] = src_i[i];
    end else begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src_i[i];
      end
      assign set_o[i] = src_i[i] & ~prev_q;
    end
  end

endmodule

// File: rtl/irq_prio_pick.sv
// Lowest-numbered request wins; one-hot grant.
module irq_prio_pick #(
  parameter int unsigned NSRC = 32
) (
  input  logic [NSRC-1:0] req_i,
  output logic [NSRC-1:0] grant_o
);

  always_comb begin
    grant_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) grant_o = '0;
      if (req_i[i]) grant_o[i] = 1'b1;
    end
  end

endmodule

// File: rtl/irq_onehot_enc.sv
// Binary position of a one-hot vector (zero when empty).
module irq_onehot_enc #(
  parameter int unsigned NSRC  = 32,
  localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]  onehot_i,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (onehot_i[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
#(
  parameter int unsigned     NSRC       = 32,
  parameter logic [NSRC-1:0] LEVEL_MASK = 32'h9080_8030,
  parameter logic [NSRC-1:0] RSVD_MASK  = 32'h0100_0040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_req_i,
  input  logic              bus_wr_i,
  input  logic [OFS_W-1:0]  bus_addr_i,
  input  logic [NSRC-1:0]   bus_wdata_i,
  output logic [NSRC-1:0]   bus_rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);

  localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]  pend_q, pend_d;
  logic [NSRC-1:0]  mask_q, mask_d;
  logic [NSRC-1:0]  mode_q, mode_d;
  logic [NSRC-1:0]  insvc_q, insvc_d;
  logic [NSRC-1:0]  set_raw, set_eff;
  logic [NSRC-1:0]  cand, grant;
  logic [IDX_W-1:0] svc_idx;
  reg_sel_e         sel;
  logic             wr_pend, wr_mode, wr_mask, wr_insvc;
  logic             mode_legal;

  irq_src_capture #(.NSRC(NSRC), .LEVEL_MASK(LEVEL_MASK)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (src_req_i),
    .set_o (set_raw)
  );

  assign set_eff = set_raw & ~RSVD_MASK;

  assign sel      = decode_ofs(bus_addr_i);
  assign wr_pend  = bus_wr_i && (sel == SEL_PEND);
  assign wr_mode  = bus_wr_i && (sel == SEL_MODE);
  assign wr_mask  = bus_wr_i && (sel == SEL_MASK);
  assign wr_insvc = bus_wr_i && (sel == SEL_INSVC);

  assign mode_legal = ((bus_wdata_i & (bus_wdata_i - 1'b1)) == '0);

  assign cand = pend_q & ~mask_q & ~mode_q;

  irq_prio_pick #(.NSRC(NSRC)) u_pick (
    .req_i   (cand),
    .grant_o (grant)
  );

  irq_onehot_enc #(.NSRC(NSRC)) u_enc (
    .onehot_i (insvc_q),
    .idx_o    (svc_idx)
  );

  always_comb begin
    pend_d = pend_q;
    if (wr_pend) pend_d = pend_d & ~bus_wdata_i;
    pend_d = pend_d | set_eff;

    mask_d = wr_mask ? bus_wdata_i : mask_q;
    mode_d = (wr_mode && mode_legal) ? bus_wdata_i : mode_q;

    if (insvc_q == '0)  insvc_d = grant;
    else if (wr_insvc)  insvc_d = insvc_q & ~bus_wdata_i;
    else                insvc_d = insvc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      mask_q  <= '1;
      mode_q  <= '0;
      insvc_q <= '0;
    end else begin
      pend_q  <= pend_d;
      mask_q  <= mask_d;
      mode_q  <= mode_d;
      insvc_q <= insvc_d;
    end
  end

  always_comb begin
    case (sel)
      SEL_PEND:  bus_rdata_o = pend_q;
      SEL_MODE:  bus_rdata_o = mode_q;
      SEL_MASK:  bus_rdata_o = mask_q;
      SEL_INSVC: bus_rdata_o = insvc_q;
      SEL_INDEX: bus_rdata_o = NSRC'(svc_idx);
      default:   bus_rdata_o = '0;
    endcase
  end

  assign irq_o = |insvc_q;
  assign fiq_o = |(pend_q & ~mask_q & mode_q);

endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk
  import irq_pend_pkg::*;
#(
  parameter int unsigned NSRC  = 32,
  localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr_i,
  input logic [OFS_W-1:0] bus_addr_i,
  input logic [NSRC-1:0]  bus_wdata_i,
  input logic [NSRC-1:0]  pend_q,
  input logic [NSRC-1:0]  mask_q,
  input logic [NSRC-1:0]  mode_q,
  input logic [NSRC-1:0]  insvc_q,
  input logic [NSRC-1:0]  set_eff,
  input logic [IDX_W-1:0] svc_idx
);

  p_insvc_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(insvc_q));

  p_insvc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (insvc_q != '0 && !(bus_wr_i && bus_addr_i == OFS_INSVC)) |=> $stable(insvc_q));

  p_load_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (insvc_q != '0 && $past(insvc_q) == '0) |->
      ((insvc_q & ($past(mask_q) | $past(mode_q))) == '0));

  p_w1c_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == OFS_PEND) |=>
      ((pend_q & $past(bus_wdata_i) & ~$past(set_eff)) == '0));

  p_mode_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mode_q));

  p_index_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (insvc_q != '0) |-> insvc_q[svc_idx]);

endmodule

bind irq_pend_ctrl irq_pend_chk #(.NSRC(NSRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .pend_q      (pend_q),
  .mask_q      (mask_q),
  .mode_q      (mode_q),
  .insvc_q     (insvc_q),
  .set_eff     (set_eff),
  .svc_idx     (svc_idx)
);

// File: tb/irq_pend_ctrl_tb.sv
module irq_pend_ctrl_tb_top;

  localparam logic [31:0] LVL  = 32'h9080_8030;
  localparam logic [31:0] RSV  = 32'h0100_0040;
  localparam logic [4:0]  A_PEND = 5'h00, A_MODE = 5'h04, A_MASK = 5'h08,
                          A_INSVC = 5'h10, A_INDEX = 5'h14;

  // {sources pulsed, mask, expected index, expected irq}
  localparam int NV = 5;
  localparam logic [69:0] VEC [NV] = '{
    {32'h0000_0C00, 32'h0000_0000, 5'd10, 1'b1},
    {32'h8000_0002, 32'h0000_0002, 5'd31, 1'b1},
    {32'h0100_0040, 32'h0000_0000, 5'd0,  1'b0},
    {32'h0000_1000, 32'hFFFF_FFFF, 5'd0,  1'b0},
    {32'h0000_0110, 32'h0000_0000, 5'd4,  1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  irq_pend_ctrl #(.NSRC(32), .LEVEL_MASK(LVL), .RSVD_MASK(RSV)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_req_i(src), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rreg(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(input logic [31:0] s);
    src = s;
    @(negedge clk);
    src = '0;
  endtask

  task automatic clear_all();
    wreg(A_PEND, 32'hFFFF_FFFF);
    wreg(A_INSVC, 32'hFFFF_FFFF);
    step(1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int passes;
    step(2);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rreg(A_PEND, v);  chk("R1 pend", v, 32'h0);
    rreg(A_INSVC, v); chk("R1 insvc", v, 32'h0);
    rreg(A_MASK, v);  chk("R1 mask", v, 32'hFFFF_FFFF);
    rreg(A_MODE, v);  chk("R1 mode", v, 32'h0);
    chk("R1 outputs", {30'h0, irq, fiq}, 32'h0);

    // Table walk: priority (R4), masking (R3), reserved (R8), index (R7)
    for (int k = 0; k < NV; k++) begin
      wreg(A_MASK, VEC[k][37:6]);
      pulse(VEC[k][69:38]);
      step(2);
      rreg(A_PEND, v);  chk("R8 table pend", v, VEC[k][69:38] & ~RSV);
      chk("R7 table irq", {31'h0, irq}, {31'h0, VEC[k][0]});
      rreg(A_INDEX, v); chk("R4 table index", v, {27'h0, VEC[k][5:1]});
      clear_all();
    end

    // R2 level vs edge with inputs held high
    wreg(A_MASK, 32'hFFFF_FFFF);
    src = 32'h0000_0410;
    step(2);
    wreg(A_PEND, 32'h0000_0410);
    rreg(A_PEND, v);
    chk("R2 held level stays set, held edge cleared", v, 32'h0000_0010);
    src = '0;
    step(1);
    wreg(A_PEND, 32'hFFFF_FFFF);
    rreg(A_PEND, v); chk("R2 level cleared after drop", v, 32'h0);

    // R4 hold while a lower source arrives, R5 zero-write no effect
    wreg(A_MASK, 32'h0);
    pulse(32'h0000_1000);
    step(2);
    pulse(32'h0000_0008);
    step(2);
    rreg(A_INDEX, v); chk("R4 hold index", v, 32'd12);
    wreg(A_PEND, 32'h0);
    rreg(A_PEND, v);  chk("R5 zero write", v, 32'h0000_1008);
    wreg(A_INSVC, 32'h0000_1000);
    step(1);
    rreg(A_INSVC, v); chk("R4 reload lowest", v, 32'h0000_0008);
    rreg(A_INDEX, v); chk("R7 index 3", v, 32'd3);
    clear_all();
    clear_all();

    // R6 fast routing
    wreg(A_MODE, 32'h0000_0008);
    rreg(A_MODE, v); chk("R6 mode write", v, 32'h0000_0008);
    wreg(A_MODE, 32'h0000_0018);
    rreg(A_MODE, v); chk("R6 illegal mode ignored", v, 32'h0000_0008);
    pulse(32'h0000_0008);
    step(2);
    chk("R6 fiq/irq", {30'h0, irq, fiq}, 32'h1);
    wreg(A_MASK, 32'h0000_0008);
    chk("R3 masked fiq", {31'h0, fiq}, 32'h0);
    wreg(A_MODE, 32'h0);
    wreg(A_MASK, 32'h0);
    step(1);
    chk("R7 irq after unroute", {30'h0, irq, fiq}, 32'h2);
    clear_all();

    // R9 stale cleanup passes
    pulse(32'h0010_0280);
    step(2);
    passes = 0;
    for (int p = 0; p < 6; p++) begin
      rreg(A_INSVC, v);
      if (v == 0) break;
      passes++;
      wreg(A_PEND, v);
      wreg(A_INSVC, v);
      step(1);
    end
    chk("R9 passes", passes, 3);
    rreg(A_PEND, v);  chk("R9 pend empty", v, 32'h0);
    rreg(A_INSVC, v); chk("R9 insvc empty", v, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule